// File: doc/BRIEF.md
# Dual-bank memory bus front-end

This block is the synchronous front end of a combined memory that places a small static RAM and a flash store behind one shared asynchronous bus. The bus master drives two active-low bank selects (one for the SRAM, one for the flash), active-low write and output enables, active-low upper and lower byte strobes, a word address and write data. The block brings every strobe into its clock domain, decides which bank owns the access, and then does one of the following:
- serves the access from an internal SRAM array;
- forwards it to a request/response port that stands in for the flash cells;
- ignores it.

Read data leaves on a 16-bit data output with a separate drive-enable, which the pad ring turns into a tristate bus. Two status flags report when neither bank is selected and when both are selected at once. Selecting both banks is an illegal bus state. In that state the block never drives data, commits no write and issues no flash request.

SRAM writes are committed when the write phase ends, that is, when either the write enable or the SRAM select rises, whichever comes first. The address, data and byte strobes used are the ones present at the end of the write phase. The byte strobes choose the half-words that take part in SRAM reads and writes.

Top module: `dbfe_front`

## Requirements
- R1: With the SRAM select low and the flash select high, accesses are served by the internal SRAM and no flash request is issued. With the flash select low and the SRAM select high, accesses go to the flash request port.
- R2: With both selects high, `standby` is 1, `bus_doe` is 0 and nothing is written or requested.
- R3: With both selects low, `sel_error` is 1, `bus_doe` is 0 and no flash request is issued. A write phase that ends because the bus entered this state is discarded.
- R4: The block drives data (`bus_doe`=1) only for a selected bank with output enable low and write enable high. While output enable is high, `bus_doe` is 0.
- R5: An SRAM write phase (write enable low, SRAM select low, flash select high) commits once, when it ends. It ends either when write enable rises or when the SRAM select rises, and it stores the address, data and byte strobes that were present in the last cycle of the phase.
- R6: On an SRAM write, the upper strobe enables bits 15:8 and the lower strobe enables bits 7:0. A byte whose strobe is high keeps its old contents.
- R7: On an SRAM read, a byte whose strobe is high reads as zero. With both strobes high, the bus is driven with 0x0000.
- R8: The SRAM holds words 0 to `SRAM_DEPTH`-1. A write at or above `SRAM_DEPTH` changes nothing, and a read there returns zero.
- R9: A flash write phase (write enable low, flash select low, SRAM select high, output enable high) produces, when it ends, a one-cycle `fl_req_valid` with `fl_req_write`=1, carrying the last address and data of the phase.
- R10: The start of a flash read phase produces a one-cycle `fl_req_valid` with `fl_req_write`=0 and the bus address. The bus is driven only after `fl_rsp_ready`, and then with the `fl_rsp_rdata` value that was accepted.
- R11: Each strobe passes through a two-flop synchroniser. `bus_doe`, `bus_dout`, `standby` and `sel_error` follow a strobe change on the third rising clock edge after it.
- R12: During reset, `bus_doe`, `fl_req_valid`, `standby` and `sel_error` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sram_sel_n | input | 1 | SRAM bank select, active low |
| bus_flash_sel_n | input | 1 | Flash bank select, active low |
| bus_we_n | input | 1 | Write enable, active low |
| bus_oe_n | input | 1 | Output enable, active low |
| bus_ub_n | input | 1 | Upper byte strobe (bits 15:8), active low |
| bus_lb_n | input | 1 | Lower byte strobe (bits 7:0), active low |
| bus_addr | input | ADDR_W | Word address |
| bus_din | input | DATA_W | Write data from the bus |
| bus_dout | output | DATA_W | Read data to the bus |
| bus_doe | output | 1 | Data drive enable for the tristate pads |
| standby | output | 1 | Neither bank selected |
| sel_error | output | 1 | Both banks selected (illegal) |
| fl_req_valid | output | 1 | One-cycle flash request strobe |
| fl_req_write | output | 1 | 1 for write, 0 for read |
| fl_req_addr | output | ADDR_W | Flash request address |
| fl_req_wdata | output | DATA_W | Flash write data |
| fl_rsp_ready | input | 1 | Flash read data is valid |
| fl_rsp_rdata | input | DATA_W | Flash read data |

## Verification
The bus outputs and both flags are due on the third rising edge after a strobe change. A flash request pulse appears on that same edge. An SRAM read that starts in the same step as the end of a write phase shows the new word one edge later, because the commit lands on that third edge. The table-driven part of the bench therefore samples on the falling edge after the fifth rising edge, when everything has settled. A separate latency test samples on the falling edges after edges one, two and three, to pin the three-edge delay exactly. Flash responses are pulsed for one cycle, and the bench checks the bus several cycles later.

// File: rtl/dbfe_pkg.sv
package dbfe_pkg;

  // Synchronised bus strobes, all active low
  typedef struct packed {
    logic sram_sel_n;
    logic flash_sel_n;
    logic we_n;
    logic oe_n;
    logic ub_n;
    logic lb_n;
  } strobe_t;

  localparam int STROBE_W = $bits(strobe_t);

  typedef enum logic [1:0] {
    BANK_IDLE  = 2'd0,
    BANK_SRAM  = 2'd1,
    BANK_FLASH = 2'd2,
    BANK_CLASH = 2'd3
  } bank_t;

endpackage

// File: rtl/dbfe_sync_pipe.sv
// Multi-stage register pipe; used as a synchroniser for strobes and as an
// aligning delay for address and data.
module dbfe_sync_pipe #(
  parameter int          WIDTH   = 1,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);

  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= RST_VAL;
          else        stage_q[s] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= RST_VAL;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign d_out = stage_q[STAGES-1];

endmodule

// File: rtl/dbfe_decode.sv
// Bank decode and access-phase edge detection on synchronised strobes.
module dbfe_decode
  import dbfe_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  strobe_t stb,
  output bank_t   bank,
  output logic    sram_rd,
  output logic    flash_rd,
  output logic    wr_phase,
  output logic    sram_commit,
  output logic    flash_commit,
  output logic    flash_rd_start
);

  logic sram_wr, flash_wr;
  logic sram_wr_q, flash_wr_q, flash_rd_q;
  logic sram_wr_d, flash_wr_d, flash_rd_d;

  always_comb begin
    unique case ({stb.sram_sel_n, stb.flash_sel_n})
      2'b11:   bank = BANK_IDLE;
      2'b01:   bank = BANK_SRAM;
      2'b10:   bank = BANK_FLASH;
      default: bank = BANK_CLASH;
    endcase
  end

  assign sram_rd  = (bank == BANK_SRAM)  && !stb.oe_n && stb.we_n;
  assign flash_rd = (bank == BANK_FLASH) && !stb.oe_n && stb.we_n;
  assign sram_wr  = (bank == BANK_SRAM)  && !stb.we_n;
  assign flash_wr = (bank == BANK_FLASH) && !stb.we_n && stb.oe_n;
  assign wr_phase = sram_wr || flash_wr;

  // A phase that ends into the clash state is dropped
  assign sram_commit    = sram_wr_q  && !sram_wr  && (bank != BANK_CLASH);
  assign flash_commit   = flash_wr_q && !flash_wr && (bank != BANK_CLASH);
  assign flash_rd_start = flash_rd   && !flash_rd_q;

  always_comb begin
    sram_wr_d  = sram_wr;
    flash_wr_d = flash_wr;
    flash_rd_d = flash_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sram_wr_q  <= 1'b0;
      flash_wr_q <= 1'b0;
      flash_rd_q <= 1'b0;
    end else begin
      sram_wr_q  <= sram_wr_d;
      flash_wr_q <= flash_wr_d;
      flash_rd_q <= flash_rd_d;
    end
  end

endmodule

// File: rtl/dbfe_sram.sv
// Byte-lane SRAM array with range check; lanes are active-high enables.
module dbfe_sram #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 64
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        wr_lanes,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [1:0]        rd_lanes,
  output logic [DATA_W-1:0] rd_data
);

  localparam int LANE_W = DATA_W / 2;
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(DEPTH);

  logic              wr_in_range, rd_in_range;
  logic [IDX_W-1:0]  wr_idx, rd_idx;

  assign wr_in_range = (wr_addr < LIMIT);
  assign rd_in_range = (rd_addr < LIMIT);
  assign wr_idx      = wr_addr[IDX_W-1:0];
  assign rd_idx      = rd_addr[IDX_W-1:0];

  generate
    for (genvar g = 0; g < 2; g++) begin : g_lane
      logic [LANE_W-1:0] mem [DEPTH];
      logic              lane_we;

      assign lane_we = wr_en && wr_in_range && wr_lanes[g];

      always_ff @(posedge clk) begin
        if (lane_we) mem[wr_idx] <= wr_data[g*LANE_W +: LANE_W];
      end

      assign rd_data[g*LANE_W +: LANE_W] =
        (rd_in_range && rd_lanes[g]) ? mem[rd_idx] : '0;
    end
  endgenerate

endmodule

// File: rtl/dbfe_flash_port.sv
// Flash-side request issue and read-response holding.
module dbfe_flash_port #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic              rd_start,
  input  logic              rd_active,
  input  logic [ADDR_W-1:0] bus_addr_s,
  input  logic [ADDR_W-1:0] cap_addr,
  input  logic [DATA_W-1:0] cap_data,
  input  logic              rsp_ready,
  input  logic [DATA_W-1:0] rsp_rdata,
  output logic              req_valid,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_have
);

  logic              valid_q, valid_d;
  logic              write_q, write_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic              load_req;
  logic              pend_q, pend_d;
  logic              have_q, have_d;
  logic [DATA_W-1:0] rdata_q;
  logic              rdata_en;

  assign load_req = commit || rd_start;
  assign rdata_en = pend_q && rsp_ready && rd_active;

  always_comb begin
    valid_d = load_req;
    write_d = commit;
    addr_d  = commit ? cap_addr : bus_addr_s;
    wdata_d = cap_data;
    pend_d  = pend_q;
    have_d  = have_q;
    if (!rd_active) begin
      pend_d = 1'b0;
      have_d = 1'b0;
    end else if (rd_start) begin
      pend_d = 1'b1;
      have_d = 1'b0;
    end else if (rdata_en) begin
      pend_d = 1'b0;
      have_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      write_q <= 1'b0;
      pend_q  <= 1'b0;
      have_q  <= 1'b0;
    end else begin
      valid_q <= valid_d;
      write_q <= write_d;
      pend_q  <= pend_d;
      have_q  <= have_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (load_req) begin
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rdata_q <= '0;
    else if (rdata_en) rdata_q <= rsp_rdata;
  end

  assign req_valid = valid_q;
  assign req_write = write_q;
  assign req_addr  = addr_q;
  assign req_wdata = wdata_q;
  assign rd_data   = rdata_q;
  assign rd_have   = have_q;

endmodule

// File: rtl/dbfe_front.sv
module dbfe_front
  import dbfe_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int DATA_W      = 16,
  parameter int SRAM_DEPTH  = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sram_sel_n,
  input  logic              bus_flash_sel_n,
  input  logic              bus_we_n,
  input  logic              bus_oe_n,
  input  logic              bus_ub_n,
  input  logic              bus_lb_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_din,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_doe,
  output logic              standby,
  output logic              sel_error,
  output logic              fl_req_valid,
  output logic              fl_req_write,
  output logic [ADDR_W-1:0] fl_req_addr,
  output logic [DATA_W-1:0] fl_req_wdata,
  input  logic              fl_rsp_ready,
  input  logic [DATA_W-1:0] fl_rsp_rdata
);

  localparam int AD_W = ADDR_W + DATA_W;

  // ---- synchronisers and aligned address/data ----
  strobe_t           stb_raw, stb_s;
  logic [AD_W-1:0]   ad_s;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] din_s;

  assign stb_raw = '{sram_sel_n:  bus_sram_sel_n,
                     flash_sel_n: bus_flash_sel_n,
                     we_n:        bus_we_n,
                     oe_n:        bus_oe_n,
                     ub_n:        bus_ub_n,
                     lb_n:        bus_lb_n};

  dbfe_sync_pipe #(
    .WIDTH  (STROBE_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL({STROBE_W{1'b1}})
  ) u_strobe_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_in (stb_raw),
    .d_out(stb_s)
  );

  dbfe_sync_pipe #(
    .WIDTH  (AD_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL({AD_W{1'b0}})
  ) u_ad_align (
    .clk  (clk),
    .rst_n(rst_n),
    .d_in ({bus_addr, bus_din}),
    .d_out(ad_s)
  );

  assign addr_s = ad_s[AD_W-1 -: ADDR_W];
  assign din_s  = ad_s[DATA_W-1:0];

  // ---- decode ----
  bank_t bank;
  logic  sram_rd, flash_rd, wr_phase;
  logic  sram_commit, flash_commit, flash_rd_start;

  dbfe_decode u_decode (
    .clk           (clk),
    .rst_n         (rst_n),
    .stb           (stb_s),
    .bank          (bank),
    .sram_rd       (sram_rd),
    .flash_rd      (flash_rd),
    .wr_phase      (wr_phase),
    .sram_commit   (sram_commit),
    .flash_commit  (flash_commit),
    .flash_rd_start(flash_rd_start)
  );

  // ---- write-phase capture (last cycle of the phase wins) ----
  logic [ADDR_W-1:0] cap_addr;
  logic [DATA_W-1:0] cap_data;
  logic [1:0]        cap_lanes;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_addr  <= '0;
      cap_data  <= '0;
      cap_lanes <= '0;
    end else if (wr_phase) begin
      cap_addr  <= addr_s;
      cap_data  <= din_s;
      cap_lanes <= {~stb_s.ub_n, ~stb_s.lb_n};
    end
  end

  // ---- SRAM bank ----
  logic [DATA_W-1:0] sram_rdata;

  dbfe_sram #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .DEPTH (SRAM_DEPTH)
  ) u_sram (
    .clk     (clk),
    .wr_en   (sram_commit),
    .wr_addr (cap_addr),
    .wr_data (cap_data),
    .wr_lanes(cap_lanes),
    .rd_addr (addr_s),
    .rd_lanes({~stb_s.ub_n, ~stb_s.lb_n}),
    .rd_data (sram_rdata)
  );

  // ---- flash request port ----
  logic [DATA_W-1:0] flash_rdata;
  logic              flash_have;

  dbfe_flash_port #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_flash (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit    (flash_commit),
    .rd_start  (flash_rd_start),
    .rd_active (flash_rd),
    .bus_addr_s(addr_s),
    .cap_addr  (cap_addr),
    .cap_data  (cap_data),
    .rsp_ready (fl_rsp_ready),
    .rsp_rdata (fl_rsp_rdata),
    .req_valid (fl_req_valid),
    .req_write (fl_req_write),
    .req_addr  (fl_req_addr),
    .req_wdata (fl_req_wdata),
    .rd_data   (flash_rdata),
    .rd_have   (flash_have)
  );

  // ---- bus output stage ----
  logic              doe_d, doe_q;
  logic [DATA_W-1:0] dout_d, dout_q;
  logic              idle_d, idle_q;
  logic              clash_d, clash_q;

  always_comb begin
    doe_d   = sram_rd || (flash_rd && flash_have);
    dout_d  = sram_rd ? sram_rdata : flash_rdata;
    idle_d  = (bank == BANK_IDLE);
    clash_d = (bank == BANK_CLASH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      doe_q   <= 1'b0;
      idle_q  <= 1'b0;
      clash_q <= 1'b0;
    end else begin
      doe_q   <= doe_d;
      idle_q  <= idle_d;
      clash_q <= clash_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     dout_q <= '0;
    else if (doe_d) dout_q <= dout_d;
  end

  assign bus_doe   = doe_q;
  assign bus_dout  = dout_q;
  assign standby   = idle_q;
  assign sel_error = clash_q;

endmodule

// File: rtl/dbfe_checker.sv
module dbfe_checker (
  input logic clk,
  input logic rst_n,
  input logic bus_oe_n,
  input logic bus_doe,
  input logic standby,
  input logic sel_error,
  input logic fl_req_valid,
  input logic fl_req_write
);

  logic [1:0] age_q;
  logic [2:0] oe_hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q     <= '0;
      oe_hist_q <= '0;
    end else begin
      if (age_q != 2'd3) age_q <= age_q + 2'd1;
      oe_hist_q <= {oe_hist_q[1:0], bus_oe_n};
    end
  end

  // R3: illegal select keeps the bus and the flash port quiet
  p_clash_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sel_error |-> (!bus_doe && !fl_req_valid));

  // R2: standby never drives the bus
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> !bus_doe);

  // R2, R3: status flags and drive enable are mutually exclusive
  p_status_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({standby, sel_error, bus_doe}));

  // R4: output enable high for three edges forbids driving
  p_oe_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((age_q == 2'd3) && (oe_hist_q == 3'b111)) |-> !bus_doe);

  // R10: a read request lasts one cycle
  p_rd_req_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_req_valid && !fl_req_write) |=> !fl_req_valid);

endmodule

bind dbfe_front dbfe_checker chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_oe_n    (bus_oe_n),
  .bus_doe     (bus_doe),
  .standby     (standby),
  .sel_error   (sel_error),
  .fl_req_valid(fl_req_valid),
  .fl_req_write(fl_req_write)
);

// File: tb/dbfe_front_tb_top.sv
`timescale 1ns/1ps
module dbfe_front_tb_top;

  localparam int ADDR_W = 20;
  localparam int DATA_W = 16;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              sram_sel_n, flash_sel_n, we_n, oe_n, ub_n, lb_n;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] din;
  logic [DATA_W-1:0] dout;
  logic              doe, sb, err;
  logic              rq_valid, rq_write;
  logic [ADDR_W-1:0] rq_addr;
  logic [DATA_W-1:0] rq_wdata;
  logic              rsp_ready;
  logic [DATA_W-1:0] rsp_rdata;

  always #4 clk = ~clk;  // 125 MHz

  dbfe_front dut_i (
    .clk(clk), .rst_n(rst_n),
    .bus_sram_sel_n(sram_sel_n), .bus_flash_sel_n(flash_sel_n),
    .bus_we_n(we_n), .bus_oe_n(oe_n), .bus_ub_n(ub_n), .bus_lb_n(lb_n),
    .bus_addr(addr), .bus_din(din), .bus_dout(dout), .bus_doe(doe),
    .standby(sb), .sel_error(err),
    .fl_req_valid(rq_valid), .fl_req_write(rq_write),
    .fl_req_addr(rq_addr), .fl_req_wdata(rq_wdata),
    .fl_rsp_ready(rsp_ready), .fl_rsp_rdata(rsp_rdata)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // Flash request monitor
  int                req_cnt = 0;
  logic              last_wr;
  logic [ADDR_W-1:0] last_addr;
  logic [DATA_W-1:0] last_data;

  always @(negedge clk) begin
    if (rst_n && rq_valid) begin
      req_cnt   <= req_cnt + 1;
      last_wr   <= rq_write;
      last_addr <= rq_addr;
      last_data <= rq_wdata;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [5:0] ctl, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    {sram_sel_n, flash_sel_n, we_n, oe_n, ub_n, lb_n} = ctl;
    addr = a;
    din  = d;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Vector: {ctl[6] = sram,flash,we,oe,ub,lb ; addr[8]; data[16];
  //          exp_doe; exp_dout[16]; exp_standby; exp_error; req[4]}
  localparam int NV = 26;
  localparam logic [52:0] VEC [NV] = '{
    {6'b111111, 8'h00, 16'h0000, 1'b0, 16'h0000, 1'b1, 1'b0, 4'd2},  // R2 standby
    {6'b010100, 8'h10, 16'h2222, 1'b0, 16'h0000, 1'b0, 1'b0, 4'd5},  // R5 write
    {6'b011100, 8'h10, 16'h2222, 1'b0, 16'h0000, 1'b0, 1'b0, 4'd5},  // R5 end by WE
    {6'b010100, 8'h05, 16'hA1B2, 1'b0, 16'h0000, 1'b0, 1'b0, 4'd5},  // R5 write
    {6'b011000, 8'h05, 16'h0000, 1'b1, 16'hA1B2, 1'b0, 1'b0, 4'd5},  // R5 end + read
    {6'b011100, 8'h05, 16'h0000, 1'b0, 16'h0000, 1'b0, 1'b0, 4'd4},  // R4 OE high
    {6'b010100, 8'h06, 16'h5566, 1'b0, 16'h0000, 1'b0, 1'b0, 4'd5},  // R5 write
    {6'b110100, 8'h06, 16'h5566, 1'b0, 16'h0000, 1'b1, 1'b0, 4'd5},  // R5 end by select
    {6'b011000, 8'h06, 16'h0000, 1'b1, 16'h5566, 1'b0, 1'b0, 4'd5},  // R5 readback
    {6'b010101, 8'h06, 16'hABCD, 1'b0, 16'h0000, 1'b0, 1'b0, 4'd6},  // R6 upper only
    {6'b011101, 8'h06, 16'hABCD, 1'b0, 16'h0000, 1'b0, 1'b0, 4'd6},
    {6'b011000, 8'h06, 16'h0000, 1'b1, 16'hAB66, 1'b0, 1'b0, 4'd6},  // R6
    {6'b011001, 8'h06, 16'h0000, 1'b1, 16'hAB00, 1'b0, 1'b0, 4'd7},  // R7 upper read
    {6'b011010, 8'h06, 16'h0000, 1'b1, 16'h0066, 1'b0, 1'b0, 4'd7},  // R7 lower read
    {6'b010110, 8'h06, 16'h1177, 1'b0, 16'h0000, 1'b0, 1'b0, 4'd6},  // R6 lower only
    {6'b011110, 8'h06, 16'h1177, 1'b0, 16'h0000, 1'b0, 1'b0, 4'd6},
    {6'b011000, 8'h06, 16'h0000, 1'b1, 16'hAB77, 1'b0, 1'b0, 4'd6},  // R6
    {6'b011011, 8'h06, 16'h0000, 1'b1, 16'h0000, 1'b0, 1'b0, 4'd7},  // R7 no lanes
    {6'b010100, 8'h50, 16'hFFFF, 1'b0, 16'h0000, 1'b0, 1'b0, 4'd8},  // R8 out of range
    {6'b011100, 8'h50, 16'hFFFF, 1'b0, 16'h0000, 1'b0, 1'b0, 4'd8},
    {6'b011000, 8'h50, 16'h0000, 1'b1, 16'h0000, 1'b0, 1'b0, 4'd8},  // R8 reads zero
    {6'b011000, 8'h10, 16'h0000, 1'b1, 16'h2222, 1'b0, 1'b0, 4'd8},  // R8 no alias
    {6'b001000, 8'h05, 16'h0000, 1'b0, 16'h0000, 1'b0, 1'b1, 4'd3},  // R3 clash read
    {6'b010100, 8'h05, 16'h9999, 1'b0, 16'h0000, 1'b0, 1'b0, 4'd3},  // R3 write start
    {6'b000100, 8'h05, 16'h9999, 1'b0, 16'h0000, 1'b0, 1'b1, 4'd3},  // R3 ends in clash
    {6'b111111, 8'h05, 16'h0000, 1'b0, 16'h0000, 1'b1, 1'b0, 4'd3}   // R3
  };

  initial begin
    rst_n     = 1'b0;
    rsp_ready = 1'b0;
    rsp_rdata = '0;
    drive(6'b111111, '0, '0);
    settle(3);
    // R12: reset state
    chk("R12 doe", 32'(doe), 32'd0);
    chk("R12 req", 32'(rq_valid), 32'd0);
    chk("R12 flags", 32'({sb, err}), 32'd0);
    rst_n = 1'b1;
    settle(4);

    for (int i = 0; i < NV; i++) begin
      logic [52:0] v;
      v = VEC[i];
      drive(v[52:47], ADDR_W'(v[46:39]), v[38:23]);
      settle(5);
      n_chk++;
      if (doe !== v[22] || (v[22] && dout !== v[21:6]) || sb !== v[5] || err !== v[4]) begin
        n_fail++;
        $display("FAIL R%0d vec %0d actual doe=%b dout=%h sb=%b err=%b expected doe=%b dout=%h sb=%b err=%b",
                 v[3:0], i, doe, dout, sb, err, v[22], v[21:6], v[5], v[4]);
      end
    end
    // R3 discarded write: word 5 still holds A1B2
    drive(6'b011000, 20'h5, '0);
    settle(5);
    chk("R3 discarded write", 32'(dout), 32'hA1B2);
    // R1: SRAM traffic and clash produce no flash requests
    chk("R1 no flash req", 32'(req_cnt), 32'd0);

    // R11: latency of three edges
    drive(6'b111111, 20'h5, '0);
    settle(5);
    drive(6'b011000, 20'h5, '0);
    settle(1);
    chk("R11 edge1", 32'(doe), 32'd0);
    settle(1);
    chk("R11 edge2", 32'(doe), 32'd0);
    settle(1);
    chk("R11 edge3", 32'({doe, dout}), {15'd0, 1'b1, 16'hA1B2});

    // R9: flash write
    drive(6'b111111, '0, '0);
    settle(5);
    drive(6'b100100, 20'h01234, 16'hBEEF);
    settle(5);
    chk("R9 no req during phase", 32'(req_cnt), 32'd0);
    drive(6'b101100, 20'h01234, 16'hBEEF);
    settle(5);
    chk("R9 one req", 32'(req_cnt), 32'd1);
    chk("R9 req fields", {last_wr, 15'(last_addr), last_data}, {1'b1, 15'h1234, 16'hBEEF});
    chk("R1 flash no drive", 32'(doe), 32'd0);

    // R10: flash read
    drive(6'b101000, 20'h00777, 16'h0000);
    settle(5);
    chk("R10 one read req", 32'(req_cnt), 32'd2);
    chk("R10 req fields", {last_wr, 15'(last_addr)}, {1'b0, 15'h0777});
    chk("R10 wait for ready", 32'(doe), 32'd0);
    rsp_ready = 1'b1;
    rsp_rdata = 16'hC0DE;
    settle(1);
    rsp_ready = 1'b0;
    rsp_rdata = 16'h0000;
    settle(3);
    chk("R10 data driven", 32'({doe, dout}), {15'd0, 1'b1, 16'hC0DE});
    // R4: OE high stops flash drive
    drive(6'b101100, 20'h00777, 16'h0000);
    settle(5);
    chk("R4 flash oe high", 32'(doe), 32'd0);
    chk("R10 no extra req", 32'(req_cnt), 32'd2);

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule